// File: doc/BRIEF.md
# Interrupt State and Reset Register Unit

This block keeps the interrupt-control state of a small 8-bit processor core: the two interrupt enable flops (a live enable and a saved copy), the two-bit interrupt mode, the interrupt vector base register, the memory refresh counter and the program counter. The instruction decoder drives it with one-cycle commands: enable, disable, mode select, register loads, refresh ticks and program counter steps. The interrupt controller signals, also for one cycle, when a maskable interrupt is taken.

Two reset inputs are provided. The full reset returns every register to its initial state. The light reset clears only the program counter and freezes everything else for that cycle. When the decoder executes a move of the vector base or the refresh counter into the accumulator, the unit returns the selected register together with a parity-flag value that mirrors the saved enable. A parameter selects whether the early NMOS defect is reproduced. In that defect, an interrupt taken in the same cycle as the read makes the flag show the already-cleared enable.

Top module: `irq_state_unit`

## Requirements
- R1: While `full_rst` is high at a rising edge, the next state has both enables at 0, mode 0, vector base 0, refresh counter 0 and program counter 0. This holds whatever the other inputs are, and also when `lite_rst` is high in the same cycle.
- R2: While `lite_rst` is high and `full_rst` is low at a rising edge, the program counter becomes 0. Both enables, the mode, the vector base and the refresh counter keep their values, and every command in that cycle is ignored.
- R3: `en_cmd` sets both `en_live` and `en_saved` to 1. `dis_cmd` sets both to 0 and wins over `en_cmd` in the same cycle.
- R4: `irq_taken` clears both enables at the next edge and wins over `en_cmd` and `dis_cmd`.
- R5: `mode_wr` stores `mode_val` (0 to 3) into `irq_mode` unchanged.
- R6: With `rd_req` high, `rd_data` shows the vector base when `rd_sel` is 0 and the refresh counter when `rd_sel` is 1. The path is combinational, with no cycle of delay.
- R7: With `rd_req` high and `NMOS_QUIRK` = 0, `rd_parity` equals the `en_saved` value held before the edge, even when `irq_taken` is high in the same cycle. With `rd_req` low, `rd_parity` is 0.
- R8: With `rd_req` high and `NMOS_QUIRK` = 1, `rd_parity` equals `en_saved` AND NOT `irq_taken`. It therefore reads 0 whenever an interrupt is taken during the read.
- R9: `vec_load` loads `vec_data` into the vector base.
- R10: `ref_load` loads `ref_data` into the refresh counter and wins over `ref_tick`. `ref_tick` adds 1 to bits 6:0 modulo 128 and keeps bit 7.
- R11: `pc_load` loads `pc_data` and wins over `pc_step`. `pc_step` adds 1 modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| full_rst | input | 1 | Synchronous full reset, active high |
| lite_rst | input | 1 | Synchronous program-counter-only reset, active high |
| en_cmd | input | 1 | Enable maskable interrupts |
| dis_cmd | input | 1 | Disable maskable interrupts |
| irq_taken | input | 1 | A maskable interrupt is accepted this cycle |
| mode_wr | input | 1 | Write interrupt mode |
| mode_val | input | 2 | New interrupt mode |
| vec_load | input | 1 | Load vector base |
| vec_data | input | DATA_W | Vector base value |
| ref_load | input | 1 | Load refresh counter |
| ref_data | input | DATA_W | Refresh counter value |
| ref_tick | input | 1 | Advance refresh counter |
| pc_load | input | 1 | Load program counter |
| pc_data | input | PC_W | Program counter value |
| pc_step | input | 1 | Increment program counter |
| rd_req | input | 1 | Register-to-accumulator read this cycle |
| rd_sel | input | 1 | 0 selects vector base, 1 selects refresh counter |
| rd_data | output | DATA_W | Selected register value |
| rd_parity | output | 1 | Parity-flag value for the read |
| en_live | output | 1 | Live interrupt enable |
| en_saved | output | 1 | Saved interrupt enable |
| irq_mode | output | 2 | Interrupt mode |
| vec_base | output | DATA_W | Vector base register |
| ref_cnt | output | DATA_W | Refresh counter |
| pc | output | PC_W | Program counter |

## Verification
The bench builds two copies side by side with the default widths (8-bit registers, 16-bit program counter): one with `NMOS_QUIRK` = 1 and one with `NMOS_QUIRK` = 0. Identical stimulus therefore shows the two parity behaviours against each other. Each copy sweeps every combination of saved enable, interrupt taken and register select. It also sweeps all four mode codes and all 256 refresh-counter start values, which covers the 7-bit wrap with bit 7 held. Both reset kinds are driven with conflicting commands in the same cycle.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  typedef enum logic [1:0] {
    IRQM_0 = 2'd0,
    IRQM_1 = 2'd1,
    IRQM_2 = 2'd2,
    IRQM_3 = 2'd3
  } irq_mode_e;

  // Refresh advance: low seven bits wrap, top bit is held.
  function automatic logic [7:0] ref_advance(input logic [7:0] cur);
    logic [6:0] low;
    low = cur[6:0] + 7'd1;
    return {cur[7], low};
  endfunction

  // Parity flag for an I/R read.
  function automatic logic read_flag(input logic quirk, input logic saved,
                                     input logic taken);
    return quirk ? (saved & ~taken) : saved;
  endfunction

endpackage

// File: rtl/irqs_enable_ff.sv
module irqs_enable_ff
  import irqs_pkg::*;
(
  input  logic       clk,
  input  logic       ev_full,
  input  logic       ev_lite,
  input  logic       en_cmd,
  input  logic       dis_cmd,
  input  logic       irq_taken,
  input  logic       mode_wr,
  input  logic [1:0] mode_val,
  output logic       en_live,
  output logic       en_saved,
  output logic [1:0] irq_mode
);

  logic      live_q, saved_q;
  irq_mode_e mode_q;
  logic      ev_take, ev_dis, ev_en, armed_q;

  assign ev_take = irq_taken;
  assign ev_dis  = dis_cmd & ~irq_taken;
  assign ev_en   = en_cmd & ~dis_cmd & ~irq_taken;

  always_ff @(posedge clk) begin
    if (ev_full) begin
      live_q  <= 1'b0;
      saved_q <= 1'b0;
      mode_q  <= IRQM_0;
    end else if (!ev_lite) begin
      if (ev_take || ev_dis) begin
        live_q  <= 1'b0;
        saved_q <= 1'b0;
      end else if (ev_en) begin
        live_q  <= 1'b1;
        saved_q <= 1'b1;
      end
      if (mode_wr) mode_q <= irq_mode_e'(mode_val);
    end
  end

  always_ff @(posedge clk) begin
    if (ev_full) armed_q <= 1'b1;
    else if (armed_q !== 1'b1) armed_q <= 1'b0;
  end

  assign en_live  = live_q;
  assign en_saved = saved_q;
  assign irq_mode = mode_q;

  assert_full_clears_R1: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    ev_full |=> (!en_live && !en_saved && irq_mode == 2'd0));
  assert_lite_holds_R2: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (ev_lite && !ev_full) |=> ($stable(en_live) && $stable(en_saved) && $stable(irq_mode)));
  assert_enable_sets_R3: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (en_cmd && !dis_cmd && !irq_taken && !ev_full && !ev_lite) |=> (en_live && en_saved));
  assert_take_clears_R4: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (irq_taken && !ev_full && !ev_lite) |=> (!en_live && !en_saved));
  assert_mode_store_R5: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (mode_wr && !ev_full && !ev_lite) |=> (irq_mode == $past(mode_val)));

endmodule

// File: rtl/irqs_vec_regs.sv
module irqs_vec_regs
  import irqs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              ev_full,
  input  logic              ev_lite,
  input  logic              vec_load,
  input  logic [DATA_W-1:0] vec_data,
  input  logic              ref_load,
  input  logic [DATA_W-1:0] ref_data,
  input  logic              ref_tick,
  input  logic              pc_load,
  input  logic [PC_W-1:0]   pc_data,
  input  logic              pc_step,
  output logic [DATA_W-1:0] vec_base,
  output logic [DATA_W-1:0] ref_cnt,
  output logic [PC_W-1:0]   pc
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic [DATA_W-1:0] vec_q, ref_q, ref_adv;
  logic [PC_W-1:0]   pc_q;
  logic              armed_q;

  generate
    if (DATA_W == 8) begin : g_ref8
      assign ref_adv = ref_advance(ref_q);
    end else begin : g_refn
      assign ref_adv = {ref_q[DATA_W-1], ref_q[DATA_W-2:0] + {{(DATA_W-2){1'b0}}, 1'b1}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ev_full) begin
      vec_q <= '0;
      ref_q <= '0;
      pc_q  <= '0;
    end else if (ev_lite) begin
      pc_q  <= '0;
    end else begin
      if (vec_load) vec_q <= vec_data;
      if (ref_load)      ref_q <= ref_data;
      else if (ref_tick) ref_q <= ref_adv;
      if (pc_load)      pc_q <= pc_data;
      else if (pc_step) pc_q <= pc_q + PC_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_full) armed_q <= 1'b1;
    else if (armed_q !== 1'b1) armed_q <= 1'b0;
  end

  assign vec_base = vec_q;
  assign ref_cnt  = ref_q;
  assign pc       = pc_q;

  assert_full_zeroes_R1: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    ev_full |=> (vec_base == '0 && ref_cnt == '0 && pc == '0));
  assert_lite_pc_only_R2: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (ev_lite && !ev_full) |=> (pc == '0 && $stable(vec_base) && $stable(ref_cnt)));
  assert_vec_load_R9: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (vec_load && !ev_full && !ev_lite) |=> (vec_base == $past(vec_data)));
  assert_ref_msb_R10: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (ref_tick && !ref_load && !ev_full && !ev_lite) |=> (ref_cnt[DATA_W-1] == $past(ref_cnt[DATA_W-1])));
  assert_pc_load_R11: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (pc_load && !ev_full && !ev_lite) |=> (pc == $past(pc_data)));

endmodule

// File: rtl/irqs_read_path.sv
module irqs_read_path
  import irqs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit NMOS_QUIRK = 1'b1
) (
  input  logic              rd_req,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] vec_base,
  input  logic [DATA_W-1:0] ref_cnt,
  input  logic              en_saved,
  input  logic              irq_taken,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_parity
);

  logic flag_raw;

  generate
    if (NMOS_QUIRK) begin : g_nmos
      assign flag_raw = read_flag(1'b1, en_saved, irq_taken);
    end else begin : g_clean
      assign flag_raw = read_flag(1'b0, en_saved, irq_taken);
    end
  endgenerate

  assign rd_data   = rd_sel ? ref_cnt : vec_base;
  assign rd_parity = rd_req & flag_raw;

  always_comb begin
    if (NMOS_QUIRK && rd_req && irq_taken)
      assert_nmos_zero_R8: assert (rd_parity == 1'b0);
    if (!rd_req)
      assert_idle_zero_R7: assert (rd_parity == 1'b0);
  end

endmodule

// File: rtl/irq_state_unit.sv
module irq_state_unit
  import irqs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PC_W       = 16,
  parameter bit NMOS_QUIRK = 1'b1
) (
  input  logic              clk,
  input  logic              full_rst,
  input  logic              lite_rst,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  input  logic              irq_taken,
  input  logic              mode_wr,
  input  logic [1:0]        mode_val,
  input  logic              vec_load,
  input  logic [DATA_W-1:0] vec_data,
  input  logic              ref_load,
  input  logic [DATA_W-1:0] ref_data,
  input  logic              ref_tick,
  input  logic              pc_load,
  input  logic [PC_W-1:0]   pc_data,
  input  logic              pc_step,
  input  logic              rd_req,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_parity,
  output logic              en_live,
  output logic              en_saved,
  output logic [1:0]        irq_mode,
  output logic [DATA_W-1:0] vec_base,
  output logic [DATA_W-1:0] ref_cnt,
  output logic [PC_W-1:0]   pc
);

  // Named reset events: the full reset outranks the light one.
  logic ev_full, ev_lite;
  assign ev_full = full_rst;
  assign ev_lite = lite_rst & ~full_rst;

  irqs_enable_ff u_en (
    .clk(clk), .ev_full(ev_full), .ev_lite(ev_lite),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .irq_taken(irq_taken),
    .mode_wr(mode_wr), .mode_val(mode_val),
    .en_live(en_live), .en_saved(en_saved), .irq_mode(irq_mode)
  );

  irqs_vec_regs #(.DATA_W(DATA_W), .PC_W(PC_W)) u_regs (
    .clk(clk), .ev_full(ev_full), .ev_lite(ev_lite),
    .vec_load(vec_load), .vec_data(vec_data),
    .ref_load(ref_load), .ref_data(ref_data), .ref_tick(ref_tick),
    .pc_load(pc_load), .pc_data(pc_data), .pc_step(pc_step),
    .vec_base(vec_base), .ref_cnt(ref_cnt), .pc(pc)
  );

  irqs_read_path #(.DATA_W(DATA_W), .NMOS_QUIRK(NMOS_QUIRK)) u_rd (
    .rd_req(rd_req), .rd_sel(rd_sel), .vec_base(vec_base), .ref_cnt(ref_cnt),
    .en_saved(en_saved), .irq_taken(irq_taken),
    .rd_data(rd_data), .rd_parity(rd_parity)
  );

  logic armed_q;
  always_ff @(posedge clk) begin
    if (ev_full) armed_q <= 1'b1;
    else if (armed_q !== 1'b1) armed_q <= 1'b0;
  end

  assert_enables_track_R3: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    en_live == en_saved);
  assert_read_select_R6: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (rd_req && rd_sel) |-> (rd_data == ref_cnt));

endmodule

// File: tb/irq_state_unit_tb.sv
module irq_state_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic full_rst, lite_rst, en_cmd, dis_cmd, irq_taken, mode_wr;
  logic [1:0] mode_val;
  logic vec_load, ref_load, ref_tick, pc_load, pc_step, rd_req, rd_sel;
  logic [7:0] vec_data, ref_data;
  logic [15:0] pc_data;

  logic [7:0] a_rd, b_rd, a_vec, b_vec, a_ref, b_ref;
  logic a_par, b_par, a_live, b_live, a_sav, b_sav;
  logic [1:0] a_mode, b_mode;
  logic [15:0] a_pc, b_pc;

  int n_chk = 0, n_bad = 0;

  irq_state_unit #(.NMOS_QUIRK(1'b1)) dut_i (
    .clk, .full_rst, .lite_rst, .en_cmd, .dis_cmd, .irq_taken, .mode_wr, .mode_val,
    .vec_load, .vec_data, .ref_load, .ref_data, .ref_tick, .pc_load, .pc_data, .pc_step,
    .rd_req, .rd_sel, .rd_data(a_rd), .rd_parity(a_par), .en_live(a_live), .en_saved(a_sav),
    .irq_mode(a_mode), .vec_base(a_vec), .ref_cnt(a_ref), .pc(a_pc));

  irq_state_unit #(.NMOS_QUIRK(1'b0)) dut_cmos_i (
    .clk, .full_rst, .lite_rst, .en_cmd, .dis_cmd, .irq_taken, .mode_wr, .mode_val,
    .vec_load, .vec_data, .ref_load, .ref_data, .ref_tick, .pc_load, .pc_data, .pc_step,
    .rd_req, .rd_sel, .rd_data(b_rd), .rd_parity(b_par), .en_live(b_live), .en_saved(b_sav),
    .irq_mode(b_mode), .vec_base(b_vec), .ref_cnt(b_ref), .pc(b_pc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    full_rst = 0; lite_rst = 0; en_cmd = 0; dis_cmd = 0; irq_taken = 0; mode_wr = 0;
    mode_val = 0; vec_load = 0; ref_load = 0; ref_tick = 0; pc_load = 0; pc_step = 0;
    rd_req = 0; rd_sel = 0; vec_data = 0; ref_data = 0; pc_data = 0;
  endtask

  task automatic edge_();
    @(posedge clk); #1;
  endtask

  task automatic chk_both_state(input string req, input logic live, input logic [1:0] m,
                                input logic [7:0] v, input logic [7:0] r, input logic [15:0] p);
    chk(req, {a_live, a_sav, b_live, b_sav}, {live, live, live, live});
    chk(req, {a_mode, b_mode}, {m, m});
    chk(req, {a_vec, b_vec}, {v, v});
    chk(req, {a_ref, b_ref}, {r, r});
    chk(req, {a_pc, b_pc}, {p, p});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    full_rst = 1;
    edge_();
    full_rst = 0;
    // R1: reset state
    chk_both_state("R1 reset", 1'b0, 2'd0, 8'h00, 8'h00, 16'h0000);

    // Populate state: R9, R5, R10, R11, R3
    vec_load = 1; vec_data = 8'h3C; ref_load = 1; ref_data = 8'hA5; ref_tick = 1;
    pc_load = 1; pc_data = 16'h1234; pc_step = 1; mode_wr = 1; mode_val = 2'd2; en_cmd = 1;
    edge_(); idle();
    chk_both_state("R9/R10/R11/R5/R3 load", 1'b1, 2'd2, 8'h3C, 8'hA5, 16'h1234);

    // R11 step
    pc_step = 1; edge_(); idle();
    chk("R11 step", a_pc, 16'h1235);
    pc_load = 1; pc_data = 16'hFFFF; edge_(); idle();
    pc_step = 1; edge_(); idle();
    chk("R11 wrap", a_pc, 16'h0000);
    pc_load = 1; pc_data = 16'h4321; edge_(); idle();

    // R2: light reset with conflicting commands
    lite_rst = 1; dis_cmd = 1; mode_wr = 1; mode_val = 2'd1; vec_load = 1; vec_data = 8'h99;
    ref_tick = 1; irq_taken = 1;
    edge_(); idle();
    chk_both_state("R2 light reset", 1'b1, 2'd2, 8'h3C, 8'hA5, 16'h0000);

    // R3 priority: disable beats enable
    en_cmd = 1; dis_cmd = 1; edge_(); idle();
    chk("R3 dis over en", {a_live, a_sav, b_live, b_sav}, 4'b0000);
    en_cmd = 1; edge_(); idle();
    chk("R3 enable", {a_live, a_sav, b_live, b_sav}, 4'b1111);
    // R4 priority
    en_cmd = 1; irq_taken = 1; edge_(); idle();
    chk("R4 take over en", {a_live, a_sav, b_live, b_sav}, 4'b0000);

    // R5 sweep of all mode codes
    for (int m = 0; m < 4; m++) begin
      mode_wr = 1; mode_val = m[1:0]; edge_(); idle();
      chk("R5 mode", {a_mode, b_mode}, {m[1:0], m[1:0]});
    end

    // R6/R7/R8 sweep: saved enable x taken x select
    for (int s = 0; s < 2; s++) begin
      for (int t = 0; t < 2; t++) begin
        for (int sel = 0; sel < 2; sel++) begin
          if (s == 1) en_cmd = 1; else dis_cmd = 1;
          edge_(); idle();
          rd_req = 1; rd_sel = sel[0]; irq_taken = t[0];
          #1;
          chk("R6 data", {a_rd, b_rd}, sel ? {8'hA5, 8'hA5} : {8'h3C, 8'h3C});
          chk("R8 nmos flag", a_par, s[0] & ~t[0]);
          chk("R7 clean flag", b_par, s[0]);
          edge_(); idle();
          chk("R4 after read", {a_sav, b_sav}, {2{s[0] & ~t[0]}});
          #1;
          chk("R7 idle flag", {a_par, b_par}, 2'b00);
        end
      end
    end

    // R10 exhaustive refresh advance and load priority
    for (int v = 0; v < 256; v++) begin
      ref_load = 1; ref_data = v[7:0]; ref_tick = 1; edge_(); idle();
      chk("R10 load over tick", a_ref, v[7:0]);
      ref_tick = 1; edge_(); idle();
      chk("R10 advance", {a_ref, b_ref},
          {2{v[7], 7'((v % 128 + 1) % 128)}});
    end

    // R1: both resets together from a nonzero state
    en_cmd = 1; mode_wr = 1; mode_val = 2'd3; vec_load = 1; vec_data = 8'h5A;
    pc_load = 1; pc_data = 16'hBEEF; edge_(); idle();
    full_rst = 1; lite_rst = 1; en_cmd = 1; vec_load = 1; vec_data = 8'h11; ref_tick = 1;
    edge_(); idle();
    chk_both_state("R1 both resets", 1'b0, 2'd0, 8'h00, 8'h00, 16'h0000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule